// File: doc/BRIEF.md
# Compare and Relative Branch Unit

This block carries out the compare-and-branch-if-different step of an 8-bit microcontroller datapath. A start strobe launches one operation. At that strobe the block latches an operand byte, an immediate byte, a signed relative displacement, the current program counter and the incoming carry. The operand byte is a working register or a byte reached through a pointer register, and the surrounding datapath supplies it. The block also decodes the opcode byte combinationally into an operand-source selection. The datapath uses that selection to fetch the operand.

The instruction occupies three bytes and runs for two machine cycles. When the operation ends, the block presents the following:
- the next program counter: the address past the instruction, plus the sign-extended displacement when the operand and the immediate differ;
- a carry that records an unsigned less-than comparison;
- a branch-taken flag;
- a one-clock done pulse.

If the latched opcode belongs to neither accepted form, the block raises an illegal flag and hands the program counter and carry back unchanged. The results hold until the next operation completes.

Top module: `cnb_unit`

## Requirements
- R1: While reset is low and after it is released, before any operation completes, `pc_next`, `carry_out`, `taken`, `illegal` and `done` are all zero.
- R2: A start accepted on a rising edge produces `done` high for exactly one clock. The pulse appears after the edge that lies MC_COUNT*CLK_PER_MC (default 4) rising edges later.
- R3: For an opcode of the form 1011_1rrr, `src_indirect` is 0 and `src_idx` equals rrr (opcode bits 2:0).
- R4: For an opcode of the form 1011_011i, `src_indirect` is 1 and `src_idx` equals {2'b00, i}, where i is opcode bit 0.
- R5: For a legal opcode whose operand differs from the immediate, `taken` is 1 and `pc_next` equals pc + 3 + the sign-extended displacement.
- R6: For a legal opcode whose operand equals the immediate, `taken` is 0, `pc_next` equals pc + 3 and `carry_out` is 0.
- R7: For a legal opcode, `carry_out` is 1 exactly when the operand is below the immediate, with both taken as unsigned 8-bit values.
- R8: All program counter arithmetic wraps modulo 2^16, in both the forward and the backward direction.
- R9: For an opcode outside both forms, the results are `illegal` = 1, `taken` = 0, `pc_next` equal to the latched pc and `carry_out` equal to the latched carry input. For a legal opcode, `illegal` is 0.
- R10: Between done pulses, `pc_next`, `carry_out`, `taken` and `illegal` hold their values. A start that arrives while an operation is in progress is ignored, and so are input changes after the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe; accepted only when idle |
| opcode | input | 8 | Instruction opcode byte |
| operand | input | 8 | Operand value fetched from the decoded source |
| imm | input | 8 | Immediate byte to compare against |
| rel | input | 8 | Signed relative displacement |
| pc_in | input | 16 | Address of the instruction's first byte |
| carry_in | input | 1 | Current carry flag |
| src_idx | output | 3 | Decoded register or pointer index |
| src_indirect | output | 1 | 1 when the operand is reached through a pointer |
| pc_next | output | 16 | Next program counter |
| carry_out | output | 1 | Updated carry flag |
| taken | output | 1 | Branch taken |
| illegal | output | 1 | Latched opcode was not a compare form |
| done | output | 1 | One-clock completion pulse |

## Verification
The assertions assume several things about the inputs:
- reset is held low at time zero;
- `done` comes only from the internal timer, so a new pulse needs a fresh start;
- the result registers load only on a completion edge.

The stimulus meets these assumptions. It drives every input on the falling edge and holds start high for one clock. It also raises start again only while an operation is running, to exercise the ignore rule, or after the previous done has been observed. Operand and immediate pairs are chosen so that below, equal and above all occur. Some of them sit at the unsigned boundary 0x7F/0x80, which a signed comparison would get wrong.

// File: rtl/cnb_pkg.sv
package cnb_pkg;
   // Opcode prefixes of the two accepted compare forms
   localparam logic [4:0] REG_FORM_PFX = 5'b10111;
   localparam logic [6:0] PTR_FORM_PFX = 7'b1011011;
   // Instruction length in bytes: opcode, immediate, displacement
   localparam int unsigned INSTR_BYTES = 3;
endpackage

// File: rtl/cnb_decode.sv
module cnb_decode
   import cnb_pkg::*;
(
   input  logic [7:0] opcode,
   output logic       legal,
   output logic       indirect,
   output logic [2:0] idx
);
   logic is_reg, is_ptr;

   always_comb begin
      is_reg   = (opcode[7:3] == REG_FORM_PFX);
      is_ptr   = (opcode[7:1] == PTR_FORM_PFX);
      legal    = is_reg | is_ptr;
      indirect = is_ptr;
      idx      = is_ptr ? {2'b00, opcode[0]} : opcode[2:0];
   end
endmodule

// File: rtl/cnb_calc.sv
module cnb_calc
   import cnb_pkg::*;
#(
   parameter int DW         = 8,
   parameter int AW         = 16,
   parameter bit BORROW_CMP = 1'b1
) (
   input  logic [DW-1:0] operand,
   input  logic [DW-1:0] imm,
   input  logic [DW-1:0] rel,
   input  logic [AW-1:0] pc,
   input  logic          cin,
   input  logic          legal,
   output logic [AW-1:0] nxt_pc,
   output logic          cout,
   output logic          take
);
   localparam int EXT = AW - DW;

   logic          below;
   logic          differ;
   logic [AW-1:0] seq_pc;
   logic [AW-1:0] rel_ext;

   generate
      if (BORROW_CMP) begin : g_borrow
         logic [DW:0] diff;
         assign diff  = {1'b0, operand} - {1'b0, imm};
         assign below = diff[DW];
      end else begin : g_direct
         assign below = (operand < imm);
      end
   endgenerate

   always_comb begin
      differ  = (operand != imm);
      seq_pc  = pc + AW'(INSTR_BYTES);
      rel_ext = {{EXT{rel[DW-1]}}, rel};
      take    = legal & differ;
      cout    = legal ? below : cin;
      if (!legal)      nxt_pc = pc;
      else if (differ) nxt_pc = seq_pc + rel_ext;
      else             nxt_pc = seq_pc;
   end
endmodule

// File: rtl/cnb_timer.sv
module cnb_timer #(
   parameter int TOTAL = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic fire
);
   localparam int CW = (TOTAL > 1) ? $clog2(TOTAL) : 1;

   logic          busy;
   logic [CW-1:0] cnt;

   assign accept = start & ~busy;
   assign fire   = busy & (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (accept) begin
         busy <= 1'b1;
         cnt  <= CW'(TOTAL - 1);
      end else if (fire) begin
         busy <= 1'b0;
      end else if (busy) begin
         cnt  <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/cnb_unit.sv
module cnb_unit #(
   parameter int DW         = 8,
   parameter int AW         = 16,
   parameter int MC_COUNT   = 2,
   parameter int CLK_PER_MC = 2,
   parameter bit BORROW_CMP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [7:0]    opcode,
   input  logic [DW-1:0] operand,
   input  logic [DW-1:0] imm,
   input  logic [DW-1:0] rel,
   input  logic [AW-1:0] pc_in,
   input  logic          carry_in,
   output logic [2:0]    src_idx,
   output logic          src_indirect,
   output logic [AW-1:0] pc_next,
   output logic          carry_out,
   output logic          taken,
   output logic          illegal,
   output logic          done
);
   localparam int TOTAL = MC_COUNT * CLK_PER_MC;

   generate
      if (AW <= DW) begin : g_bad_aw
         $error("cnb_unit: AW must exceed DW");
      end
      if (DW < 2) begin : g_bad_dw
         $error("cnb_unit: DW must be at least 2");
      end
      if (TOTAL < 1) begin : g_bad_total
         $error("cnb_unit: cycle count must be positive");
      end
   endgenerate

   logic          legal_now;
   logic          accept, fire;
   logic          legal_q, cin_q;
   logic [DW-1:0] opd_q, imm_q, rel_q;
   logic [AW-1:0] pc_q;
   logic [AW-1:0] calc_pc;
   logic          calc_c, calc_take;

   cnb_decode u_dec (
      .opcode   (opcode),
      .legal    (legal_now),
      .indirect (src_indirect),
      .idx      (src_idx)
   );

   cnb_timer #(.TOTAL(TOTAL)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .accept (accept),
      .fire   (fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         legal_q <= 1'b0;
         cin_q   <= 1'b0;
         opd_q   <= '0;
         imm_q   <= '0;
         rel_q   <= '0;
         pc_q    <= '0;
      end else if (accept) begin
         legal_q <= legal_now;
         cin_q   <= carry_in;
         opd_q   <= operand;
         imm_q   <= imm;
         rel_q   <= rel;
         pc_q    <= pc_in;
      end
   end

   cnb_calc #(.DW(DW), .AW(AW), .BORROW_CMP(BORROW_CMP)) u_calc (
      .operand (opd_q),
      .imm     (imm_q),
      .rel     (rel_q),
      .pc      (pc_q),
      .cin     (cin_q),
      .legal   (legal_q),
      .nxt_pc  (calc_pc),
      .cout    (calc_c),
      .take    (calc_take)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_next   <= '0;
         carry_out <= 1'b0;
         taken     <= 1'b0;
         illegal   <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= fire;
         if (fire) begin
            pc_next   <= calc_pc;
            carry_out <= calc_c;
            taken     <= calc_take;
            illegal   <= ~legal_q;
         end
      end
   end
endmodule

// File: rtl/cnb_unit_chk.sv
module cnb_unit_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          done,
   input logic          taken,
   input logic          carry_out,
   input logic          illegal,
   input logic [AW-1:0] pc_next
);
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R2
   AST_HOLD_PC: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(pc_next)); // R10
   AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({taken, carry_out, illegal})); // R10
   AST_EQUAL_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !illegal && !taken) |-> !carry_out); // R6
   AST_ILLEGAL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !taken); // R9
endmodule

bind cnb_unit cnb_unit_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .done      (done),
   .taken     (taken),
   .carry_out (carry_out),
   .illegal   (illegal),
   .pc_next   (pc_next)
);

// File: tb/tb_cnb_unit.sv
`timescale 1ns/1ps
module tb_cnb_unit;
   localparam int TOTAL = 4;
   localparam int NV    = 8;
   // {opcode, operand, imm, rel, pc, carry_in}
   localparam logic [48:0] VEC [NV] = '{
      {8'hB8, 8'h10, 8'h10, 8'h05, 16'h0100, 1'b1},
      {8'hBF, 8'h05, 8'h20, 8'h10, 16'h0200, 1'b0},
      {8'hB6, 8'h80, 8'h7F, 8'hF0, 16'h1000, 1'b1},
      {8'hB7, 8'h00, 8'hFF, 8'h80, 16'h0000, 1'b0},
      {8'hBC, 8'hFF, 8'h00, 8'h7F, 16'hFFFE, 1'b0},
      {8'hA5, 8'h01, 8'h02, 8'h10, 16'h1234, 1'b1},
      {8'hB5, 8'h01, 8'h01, 8'h10, 16'h4321, 1'b0},
      {8'hBA, 8'h7F, 8'h80, 8'h01, 16'h8000, 1'b1}
   };

   logic clk = 0, rst_n = 0, start = 0, carry_in = 0;
   logic [7:0] opcode = 0, operand = 0, imm = 0, rel = 0;
   logic [15:0] pc_in = 0;
   logic [2:0] src_idx;
   logic src_indirect, carry_out, taken, illegal, done;
   logic [15:0] pc_next;
   int checks = 0, fails = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   cnb_unit dut (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic expect_res(input logic [48:0] v, output logic [15:0] epc,
                             output bit ec, output bit et, output bit ei);
      logic [7:0] op, a, b, r;
      logic [15:0] pc;
      bit ci, lg;
      {op, a, b, r, pc, ci} = v;
      lg = (op[7:3] == 5'b10111) || (op[7:1] == 7'b1011011);
      if (!lg) begin
         epc = pc; ec = ci; et = 0; ei = 1;
      end else begin
         ei = 0;
         ec = (a < b);
         et = (a != b);
         epc = pc + 16'd3 + (et ? {{8{r[7]}}, r} : 16'd0);
      end
   endtask

   task automatic drive(input logic [48:0] v);
      {opcode, operand, imm, rel, pc_in, carry_in} = v;
   endtask

   // launch on a falling edge; verify done timing (R2) and results
   task automatic run_vec(input logic [48:0] v, input bit disturb);
      logic [15:0] epc;
      bit ec, et, ei;
      expect_res(v, epc, ec, et, ei);
      drive(v);
      start = 1;
      @(posedge clk);
      @(negedge clk);
      start = 0;
      for (int i = 1; i <= TOTAL; i++) begin
         if (disturb && i == 1) begin
            drive({8'hB8, 8'h00, 8'h55, 8'h40, 16'h7777, 1'b1}); // R10 busy restart
            start = 1;
         end
         @(negedge clk);
         start = 0;
         chk(done == (i == TOTAL), "R2 done timing", done, i == TOTAL);
      end
      if (ei) chk(illegal && pc_next == epc && carry_out == ec && !taken,
                  "R9 illegal hold", pc_next, epc);
      else begin
         chk(!illegal, "R9 legal flag", illegal, 0);
         chk(taken == et, et ? "R5 taken" : "R6 not taken", taken, et);
         chk(pc_next == epc, et ? "R5/R8 target pc" : "R6 seq pc", pc_next, epc);
         chk(carry_out == ec, "R7 carry", carry_out, ec);
      end
      @(negedge clk);
      chk(!done, "R2 single pulse", done, 0);
   endtask

   initial begin
      logic [15:0] keep_pc;
      repeat (3) @(negedge clk);
      chk(pc_next == 0 && !carry_out && !taken && !illegal && !done,
          "R1 reset state", pc_next, 0);
      rst_n = 1;
      @(negedge clk);
      chk(pc_next == 0 && !done && !taken, "R1 after release", pc_next, 0);

      // decode of both forms
      for (int k = 0; k < 8; k++) begin
         opcode = 8'hB8 | 8'(k);
         #1;
         chk(!src_indirect && src_idx == 3'(k), "R3 register decode", src_idx, k);
      end
      for (int k = 0; k < 2; k++) begin
         opcode = 8'hB6 | 8'(k);
         #1;
         chk(src_indirect && src_idx == 3'(k), "R4 pointer decode", src_idx, k);
      end
      @(negedge clk);

      // table walk
      for (int n = 0; n < NV; n++) run_vec(VEC[n], 1'b0);

      // R10: start while busy ignored, first operation's result delivered
      run_vec({8'hB9, 8'h30, 8'h31, 8'hFE, 16'h0050, 1'b0}, 1'b1);

      // R10: results held while inputs change without start
      keep_pc = pc_next;
      drive({8'hBB, 8'h01, 8'h09, 8'h22, 16'h9999, 1'b1});
      repeat (6) @(negedge clk);
      chk(pc_next == keep_pc && !done, "R10 hold between ops", pc_next, keep_pc);

      // R8 backward wrap explicitly
      run_vec({8'hBD, 8'h02, 8'h01, 8'hF8, 16'h0001, 1'b0}, 1'b0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule